// File: doc/BRIEF.md
# Double-Width Funnel Shifter with Flags

This block performs double-precision shifts for an integer datapath. A primary source and a second operand are joined into one field of twice the operand width. The field is shifted left or right, and the sized result is merged back into the destination register. The second operand sits in a small dedicated register. A separate write operation loads it with the XOR of two inputs.

The shift itself is combinational. The count is masked according to the operand size and then reduced modulo twice the operand width. A large count therefore first draws bits from the second operand and then brings source bits back around. Carry, extended carry, overflow, zero, sign and parity are computed from the shift. Each one is written only when its bit in the update mask is set. When the masked count is zero, no flag changes.

Top module: `dbl_shift_unit`

## Requirements
- R1: The second-operand register resets to zero. In a cycle with `aux_wr_en` high it loads `aux_wr_a ^ aux_wr_b`, and the new value is used from the next cycle on. In any other cycle it holds its value.
- R2: For `op_size` 3 (8 bytes) the count uses all 6 bits of `shift_count`. For `op_size` 0, 1 and 2 (1, 2 and 4 bytes) only bits 4:0 are used, so bit 5 has no effect.
- R3: The effective count n is the masked count modulo 2w, where w is the operand width in bits. When n is 0 the sized result equals the source.
- R4: A left shift (`shift_right` = 0) gives the upper w bits of the 2w-bit field {source, second operand} rotated left by n.
- R5: A right shift (`shift_right` = 1) gives the lower w bits of the 2w-bit field {second operand, source} rotated right by n.
- R6: The merge depends on size. For 1 and 2 bytes, destination bits above the size keep their old value. For 4 bytes, bits 63:32 become zero. For 8 bytes, all 64 bits are the result.
- R7: When the masked count is zero, `flags_out` equals `flags_in` regardless of the mask.
- R8: For a left shift the carry is source bit w−n when 0<n≤w, second-operand bit 2w−n when n>w, and second-operand bit 0 when n=0 with a nonzero masked count. Carry (bit 0) and extended carry (bit 5) both take this value when they are enabled.
- R9: For a right shift the carry is source bit n−1 when 0<n≤w, second-operand bit n−w−1 when n>w, and second-operand bit w−1 when n=0 with a nonzero masked count.
- R10: Overflow (bit 4) is source bit w−1 XOR result bit w−1.
- R11: Zero (bit 2) is set when the low w result bits are all zero. Sign (bit 3) is result bit w−1. Parity (bit 1) is set when the low result byte holds an even number of ones. Any flag bit whose `flag_mask` bit is clear keeps its `flags_in` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the second-operand register |
| rst_n | input | 1 | Synchronous active-low reset |
| aux_wr_en | input | 1 | Load the second-operand register |
| aux_wr_a | input | 64 | First load input |
| aux_wr_b | input | 64 | Second load input, XORed with the first |
| shift_right | input | 1 | 0 = left shift, 1 = right shift |
| op_size | input | 2 | 0/1/2/3 = 1/2/4/8 bytes |
| src | input | 64 | Primary source |
| shift_count | input | 6 | Raw shift count |
| dest_old | input | 64 | Previous destination value |
| flag_mask | input | 6 | Flag update enables, same layout as the flags |
| flags_in | input | 6 | Current flags |
| dest_new | output | 64 | Merged destination |
| flags_out | output | 6 | Updated flags |

## Verification
Assertions check these properties on every cycle:
- the register loads and holds as R1 describes;
- the flags are unchanged for a zero masked count;
- flags outside the mask are untouched;
- carry and extended carry agree whenever both are enabled;
- the upper destination bits are kept or zeroed according to size.

The actual bit values can be shown only by the bench's scenarios. These cover the rotated results across the wrap at n=w and n>w, the carry chosen in each count range, the identity case where the masked count is nonzero but n is zero, and the ignored count bit 5 for sizes below 8 bytes. The bench checks them against a bit-serial reference model.

// File: rtl/dsu_pkg.sv
// Shared constants and types for the double-width funnel shifter.
// Assumes a 64-bit datapath and four operand sizes (1, 2, 4 and 8 bytes).
package dsu_pkg;
    localparam int XLEN   = 64;
    localparam int NSIZE  = 4;
    localparam int CNT_W  = 6;
    localparam int FLAG_W = 6;

    // Flag bit positions.
    localparam int FB_CF  = 0;
    localparam int FB_PF  = 1;
    localparam int FB_ZF  = 2;
    localparam int FB_SF  = 3;
    localparam int FB_OF  = 4;
    localparam int FB_ECF = 5;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } opsize_e;
endpackage

// File: rtl/dsu_aux_reg.sv
// Second-operand register for double-width shifts.
// It loads the XOR of its two inputs when wr_en is high and holds otherwise.
// Assumes a synchronous active-low reset that clears it to zero.
module dsu_aux_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_a,
    input  logic [W-1:0] wr_b,
    output logic [W-1:0] q
);
    // Register update: clear on reset, load the XOR on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wr_a ^ wr_b;
    end

    // R1: a write becomes visible on the next cycle
    a_r1_aux_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wr_a ^ wr_b)));

    // R1: the register holds when there is no write
    a_r1_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/dsu_funnel_core.sv
// Funnel rotate for one operand width W.
// The source and the second operand form a 2W-bit ring: {a,b} for a left shift,
// {b,a} for a right shift. The output is the W-bit window left after rotating
// by the count modulo 2W. The carry is the last bit moved out of that window.
// Assumes cnt_m has already been masked for the operand size.
module dsu_funnel_core #(
    parameter int W = 8
) (
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [5:0]   cnt_m,
    input  logic         go_right,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int RW = 2 * W;

    logic [6:0]      m7;
    logic [6:0]      n7;
    logic [RW-1:0]   ring;
    logic [2*RW-1:0] dbl;

    assign m7   = {1'b0, cnt_m};
    assign n7   = m7 & 7'(RW - 1);
    assign ring = go_right ? {src_b, src_a} : {src_a, src_b};
    assign dbl  = {ring, ring};

    // Window select and carry-bit index for the effective count.
    always_comb begin
        int ni;
        int ki;
        int ci;
        ni = int'(n7);
        if (go_right) begin
            ki = ni;
            ci = (ni == 0) ? RW - 1 : ni - 1;
        end else begin
            ki = (ni <= W) ? W - ni : 3 * W - ni;
            ci = (ni == 0) ? 0 : RW - ni;
        end
        res  = W'(dbl >> ki);
        cout = 1'(ring >> ci);
    end
endmodule

// File: rtl/dsu_flag_unit.sv
// Flag merge for the funnel shifter.
// Each flag takes its computed value only when its mask bit is set.
// When the masked count is zero, all flags pass through unchanged.
// Assumes the computed flags are already reduced to the operand width.
module dsu_flag_unit
    import dsu_pkg::*;
(
    input  logic              cnt_zero,
    input  logic              carry,
    input  logic              ovf,
    input  logic              res_zero,
    input  logic              res_sign,
    input  logic              par_even,
    input  logic [FLAG_W-1:0] upd_mask,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_out
);
    logic [FLAG_W-1:0] calc;

    // Assemble the computed flags in their bit positions.
    always_comb begin
        calc         = '0;
        calc[FB_CF]  = carry;
        calc[FB_ECF] = carry;
        calc[FB_OF]  = ovf;
        calc[FB_ZF]  = res_zero;
        calc[FB_SF]  = res_sign;
        calc[FB_PF]  = par_even;
    end

    // Select computed or old flags per bit, or freeze all for a zero count.
    always_comb begin
        if (cnt_zero)
            flags_out = flags_in;
        else
            flags_out = (flags_in & ~upd_mask) | (calc & upd_mask);
    end
endmodule

// File: rtl/dbl_shift_unit.sv
// Double-width funnel shifter with flag generation (top level).
// One funnel core per operand size is built and the core for op_size is
// selected. The sized result is merged into dest_old and the flags are
// updated under flag_mask.
// Assumes op_size codes 0..3 mean 1, 2, 4 and 8 bytes.
module dbl_shift_unit
    import dsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_wr_en,
    input  logic [XLEN-1:0]   aux_wr_a,
    input  logic [XLEN-1:0]   aux_wr_b,
    input  logic              shift_right,
    input  logic [1:0]        op_size,
    input  logic [XLEN-1:0]   src,
    input  logic [CNT_W-1:0]  shift_count,
    input  logic [XLEN-1:0]   dest_old,
    input  logic [FLAG_W-1:0] flag_mask,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [XLEN-1:0]   dest_new,
    output logic [FLAG_W-1:0] flags_out
);
    opsize_e          sz;
    logic [XLEN-1:0]  aux_q;
    logic [CNT_W-1:0] cnt_m;
    logic [XLEN-1:0]  res_arr [NSIZE];
    logic [NSIZE-1:0] cy_arr;
    logic [XLEN-1:0]  res_sel;
    logic             res_msb;
    logic             src_msb;

    assign sz = opsize_e'(op_size);

    dsu_aux_reg #(.W(XLEN)) u_aux (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (aux_wr_en),
        .wr_a  (aux_wr_a),
        .wr_b  (aux_wr_b),
        .q     (aux_q)
    );

    // Count masking: 6 bits for 8-byte operands, 5 bits otherwise.
    always_comb begin
        if (sz == SZ_D)
            cnt_m = shift_count;
        else
            cnt_m = {1'b0, shift_count[4:0]};
    end

    // One funnel core per operand size.
    for (genvar gi = 0; gi < NSIZE; gi++) begin : g_size
        localparam int W = 8 << gi;
        logic [W-1:0] part_res;

        dsu_funnel_core #(.W(W)) u_core (
            .src_a    (src[W-1:0]),
            .src_b    (aux_q[W-1:0]),
            .cnt_m    (cnt_m),
            .go_right (shift_right),
            .res      (part_res),
            .cout     (cy_arr[gi])
        );

        assign res_arr[gi] = XLEN'(part_res);
    end

    assign res_sel = res_arr[op_size];

    // Pick the size-dependent MSBs and merge the result into the destination.
    always_comb begin
        case (sz)
            SZ_B: begin
                res_msb  = res_sel[7];
                src_msb  = src[7];
                dest_new = {dest_old[XLEN-1:8], res_sel[7:0]};
            end
            SZ_H: begin
                res_msb  = res_sel[15];
                src_msb  = src[15];
                dest_new = {dest_old[XLEN-1:16], res_sel[15:0]};
            end
            SZ_W: begin
                res_msb  = res_sel[31];
                src_msb  = src[31];
                dest_new = {32'd0, res_sel[31:0]};
            end
            default: begin
                res_msb  = res_sel[XLEN-1];
                src_msb  = src[XLEN-1];
                dest_new = res_sel;
            end
        endcase
    end

    dsu_flag_unit u_flags (
        .cnt_zero  (cnt_m == '0),
        .carry     (cy_arr[op_size]),
        .ovf       (src_msb ^ res_msb),
        .res_zero  (res_sel == '0),
        .res_sign  (res_msb),
        .par_even  (~^res_sel[7:0]),
        .upd_mask  (flag_mask),
        .flags_in  (flags_in),
        .flags_out (flags_out)
    );

    // R7: a zero masked count leaves every flag as it was
    a_r7_count_zero_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_m == '0) |-> (flags_out == flags_in));

    // R11: flags outside the mask are never altered
    a_r11_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (((flags_out ^ flags_in) & ~flag_mask) == '0));

    // R8: carry and extended carry agree whenever both are updated
    a_r8_carry_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_m != '0) && flag_mask[FB_CF] && flag_mask[FB_ECF])
            |-> (flags_out[FB_CF] == flags_out[FB_ECF]));

    // R6: narrow sizes keep the upper destination bits
    a_r6_narrow_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (op_size[1] == 1'b0) |-> (dest_new[XLEN-1:16] == dest_old[XLEN-1:16]));

    // R6: the 4-byte size clears the upper half
    a_r6_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_size == 2'd2) |-> (dest_new[XLEN-1:32] == 32'd0));
endmodule

// File: tb/dbl_shift_unit_tb.sv
// Bench for dbl_shift_unit. A bit-serial reference model is compared with the
// design on every clock cycle.
module dbl_shift_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aux_wr_en = 1'b0;
    logic [63:0] aux_wr_a = '0;
    logic [63:0] aux_wr_b = '0;
    logic        shift_right = 1'b0;
    logic [1:0]  op_size = '0;
    logic [63:0] src = '0;
    logic [5:0]  shift_count = '0;
    logic [63:0] dest_old = '0;
    logic [5:0]  flag_mask = '0;
    logic [5:0]  flags_in = '0;
    logic [63:0] dest_new;
    logic [5:0]  flags_out;

    int          checks = 0;
    int          errors = 0;
    logic [63:0] aux_model = '0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    dbl_shift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .aux_wr_en(aux_wr_en), .aux_wr_a(aux_wr_a),
        .aux_wr_b(aux_wr_b), .shift_right(shift_right), .op_size(op_size),
        .src(src), .shift_count(shift_count), .dest_old(dest_old),
        .flag_mask(flag_mask), .flags_in(flags_in), .dest_new(dest_new),
        .flags_out(flags_out)
    );

    // Bit-serial reference: the field is moved one position per step.
    function automatic void ref_model(input bit right, input int sz,
        input logic [63:0] s_in, input logic [63:0] d_in, input logic [5:0] c,
        input logic [63:0] dold, input logic [5:0] m, input logic [5:0] fin,
        output logic [63:0] dexp, output logic [5:0] fexp);
        int          w;
        int          mc;
        int          n;
        logic [63:0] wm;
        logic [63:0] s;
        logic [63:0] d;
        logic        cy;
        logic [5:0]  calc;
        w  = 8 << sz;
        mc = (sz == 3) ? int'(c) : int'(c) % 32;
        n  = mc % (2 * w);
        wm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        s  = s_in & wm;
        d  = d_in & wm;
        cy = right ? d[w-1] : d[0];
        for (int i = 0; i < n; i++) begin
            logic bs;
            logic bd;
            if (!right) begin
                bs = s[w-1];
                bd = d[w-1];
                s  = ((s << 1) | 64'(bd)) & wm;
                d  = ((d << 1) | 64'(bs)) & wm;
            end else begin
                bs = s[0];
                bd = d[0];
                s  = (s >> 1) | (64'(bd) << (w - 1));
                d  = (d >> 1) | (64'(bs) << (w - 1));
            end
            cy = bs;
        end
        case (sz)
            0: dexp = {dold[63:8], s[7:0]};
            1: dexp = {dold[63:16], s[15:0]};
            2: dexp = {32'd0, s[31:0]};
            default: dexp = s;
        endcase
        calc    = '0;
        calc[0] = cy;
        calc[5] = cy;
        calc[4] = s_in[w-1] ^ s[w-1];
        calc[2] = (s == 64'd0);
        calc[3] = s[w-1];
        calc[1] = ~^s[7:0];
        if (mc == 0) fexp = fin;
        else         fexp = (fin & ~m) | (calc & m);
    endfunction

    // Drive one operation, compare it before the clock edge, then advance the model.
    task automatic apply(input bit right, input int sz, input logic [63:0] s,
        input logic [5:0] c, input logic [63:0] dold, input logic [5:0] m,
        input logic [5:0] fin, input bit wr, input logic [63:0] wa,
        input logic [63:0] wb, input string tag);
        logic [63:0] dexp;
        logic [5:0]  fexp;
        @(negedge clk);
        shift_right = right;
        op_size     = 2'(sz);
        src         = s;
        shift_count = c;
        dest_old    = dold;
        flag_mask   = m;
        flags_in    = fin;
        aux_wr_en   = wr;
        aux_wr_a    = wa;
        aux_wr_b    = wb;
        #5;
        ref_model(right, sz, s, aux_model, c, dold, m, fin, dexp, fexp);
        checks++;
        if (dest_new !== dexp) begin
            errors++;
            $display("FAIL %s dest: actual %h expected %h", tag, dest_new, dexp);
        end
        checks++;
        if (flags_out !== fexp) begin
            errors++;
            $display("FAIL %s flags: actual %b expected %b", tag, flags_out, fexp);
        end
        @(posedge clk);
        if (wr && rst_n) aux_model = wa ^ wb;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset the second operand reads as zero (n = w pulls it in whole)
        apply(0, 0, 64'hFF, 6'd8, 64'h0, 6'h3F, 6'h00, 0, 0, 0, "R1 reset");
        // R1: load the register with the XOR of its inputs
        apply(0, 3, 64'h0, 6'd0, 64'h0, 6'h00, 6'h00, 1,
              64'h5555_AAAA_0F0F_F0F0, 64'h0123_4567_89AB_CDEF, "R1 load");
        apply(0, 3, 64'h0, 6'd1, 64'h0, 6'h3F, 6'h00, 0, 0, 0, "R1 loaded value");
        // R3/R7: zero count returns the source and freezes the flags
        apply(0, 2, 64'hDEAD_BEEF_1234_5678, 6'd0, 64'hFFFF_FFFF_0000_0000,
              6'h3F, 6'h2A, 0, 0, 0, "R3 R7 zero count");
        // R2: count bit 5 is ignored below 8 bytes
        apply(1, 0, 64'h81, 6'd32, 64'h1111_2222_3333_4444, 6'h3F, 6'h15, 0, 0, 0, "R2 bit5 ignored");
        apply(0, 3, 64'h8000_0000_0000_0001, 6'd32, 64'h0, 6'h3F, 6'h00, 0, 0, 0, "R2 full count");
        // R3/R8: count 16 on bytes gives n=0, identity result, carry from second bit 0
        apply(0, 0, 64'h5A, 6'd16, 64'h0, 6'h3F, 6'h00, 0, 0, 0, "R3 R8 wrap to zero left");
        apply(1, 0, 64'h5A, 6'd16, 64'h0, 6'h3F, 6'h3F, 0, 0, 0, "R3 R9 wrap to zero right");
        // R4/R8: left shifts below, at and above the width
        apply(0, 1, 64'h0000_0000_0000_C3A5, 6'd5, 64'hABCD_0000_0000_0000, 6'h3F, 6'h00, 0, 0, 0, "R4 R8 left n<w");
        apply(0, 1, 64'h0000_0000_0000_C3A5, 6'd16, 64'h0, 6'h3F, 6'h00, 0, 0, 0, "R4 R8 left n=w");
        apply(0, 1, 64'h0000_0000_0000_C3A5, 6'd20, 64'h0, 6'h3F, 6'h00, 0, 0, 0, "R4 R8 left n>w");
        // R5/R9: right shifts below, at and above the width
        apply(1, 2, 64'h0000_0000_8765_4321, 6'd7, 64'h0, 6'h3F, 6'h00, 0, 0, 0, "R5 R9 right n<w");
        apply(1, 0, 64'hF3, 6'd12, 64'h0, 6'h3F, 6'h00, 0, 0, 0, "R5 R9 right n>w");
        apply(1, 3, 64'hFEDC_BA98_7654_3210, 6'd63, 64'h0, 6'h3F, 6'h00, 0, 0, 0, "R5 R9 right 8B");
        // R6: merge by size
        apply(0, 0, 64'h3C, 6'd3, 64'hFFFF_FFFF_FFFF_FFFF, 6'h00, 6'h00, 0, 0, 0, "R6 byte merge");
        apply(1, 2, 64'hFFFF_FFFF_1234_5678, 6'd4, 64'hFFFF_FFFF_FFFF_FFFF, 6'h00, 6'h00, 0, 0, 0, "R6 word zero upper");
        // R10: sign change sets overflow
        apply(0, 0, 64'h40, 6'd1, 64'h0, 6'h10, 6'h00, 0, 0, 0, "R10 overflow");
        // R11: a partial mask updates only the enabled flags
        apply(0, 0, 64'h01, 6'd4, 64'h0, 6'h0E, 6'h31, 0, 0, 0, "R11 partial mask");
        apply(1, 0, 64'h00, 6'd3, 64'h0, 6'h06, 6'h00, 1, 64'h0, 64'h0, "R11 zero parity");
        apply(1, 0, 64'h00, 6'd3, 64'h0, 6'h06, 6'h00, 0, 0, 0, "R11 zero result");
        for (int i = 0; i < 600; i++) begin
            apply(1'($urandom), int'($urandom % 4), {$urandom, $urandom}, 6'($urandom),
                  {$urandom, $urandom}, 6'($urandom), 6'($urandom), ($urandom % 8) == 0,
                  {$urandom, $urandom}, {$urandom, $urandom}, "random R4 R5 R11");
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule